// File: doc/BRIEF.md
# Circulating Serial Word Store

This block models a recirculating serial main memory in synchronous logic. The store is 32 tanks of 32 words, 18 bits per word. All tanks circulate in lockstep past a single read/write head, one bit per clock, least significant bit first. A word slot can only be read or written while it passes the head. The time from a request to its completion therefore depends on where the circulation stands when the request arrives. The requester waits on a busy flag and sees a one-cycle done pulse when the transfer has finished.

A short access moves one word. Its lowest bit cell is never usable, so a short word carries 17 significant bits. A long access joins an even slot n and the odd slot n+1 above it into one 36-bit value. Only the lowest bit of slot n is lost, which leaves 35 usable bits. When reset is released, a fixed loader makes one full circulation of tank 0 and writes a computed start-up program into it. Requests are accepted only after the loader has finished.

Top module: `circDelayStore`

## Requirements
- R1: `reqAddr[9:5]` selects the tank and `reqAddr[4:0]` selects the word slot. Words are 18 bits wide.
- R2: After reset, `busy` stays high for exactly 576 clocks while tank 0 is loaded. Slot i, for i from 0 to 30, receives ((i*2749+1234) mod 2^18) with bit 0 cleared. Slot 31 receives zero.
- R3: After k clocks since reset release, the head holds bit (k mod 18) of slot 31-((k div 18) mod 32). Slots pass in descending order and bits pass LSB first.
- R4: A short transfer occupies the first 18 clocks, after the accepting clock, that begin at bit 0 of the requested slot. `done` is high in the clock after the last bit, and `busy` is low from that clock on.
- R5: A short write stores `wrData[17:1]` and never stores bit 0. A short read returns the word in `rdData[17:0]` with bit 0 forced to 0 and `rdData[35:18]` at zero.
- R6: A long access ignores address bit 0 and uses the even slot n. Slot n+1 transfers first, then slot n on the next word time, and `done` follows 36 bits after the start. The value layout is `{slot n+1[17:0], slot n[17:1], 0}`. A long write stores `wrData[35:18]` into slot n+1 and `wrData[17:1]` into slot n.
- R7: Only one request is handled at a time. A `reqValid` seen while `busy` is high, including during the loader, is ignored.
- R8: With no request pending, stored words keep their values through any number of circulations.
- R9: `done` is a single-cycle pulse and occurs only at the end of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe; taken when busy is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLong | input | 1 | 1 = long (paired) access |
| reqAddr | input | 10 | Tank in [9:5], slot in [4:0] |
| wrData | input | 36 | Write value (short uses [17:1]) |
| busy | output | 1 | Loader or transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 36 | Read result, valid from done |

## Verification
The bench predicts the exact completion cycle of every transfer from the circulation phase. A design that started a transfer one bit late or early, or that waited an extra revolution after a request landed exactly one clock before its slot, would be reported by its done cycle. Long accesses at slot 30 of tank 31 and at an odd address catch designs that swap the two halves, do not force the address to even, or drop the usable low bit of the upper slot. The bench also writes all ones to slot 31 and sends requests while busy is high, both during the loader and during a transfer. A design that stored the lost bit or took a request while busy would return altered data on the next read.

// File: rtl/dlsPkg.sv
package dlsPkg;

  typedef struct packed {
    logic capture;   // latch a new request this cycle
    logic bootWr;    // loader writes the head bit of tank 0
    logic xferEn;    // head bit belongs to the active transfer
    logic isWrite;   // direction of the capture or transfer
    logic highHalf;  // transfer is in the upper slot of a long pair
  } dlsStrobes_t;

  function automatic logic [31:0] bootPattern(input logic [31:0] idx);
    logic [31:0] v;
    v = idx * 32'd2749 + 32'd1234;
    return v & ~32'd1;
  endfunction

endpackage

// File: rtl/dlsTiming.sv
module dlsTiming #(
  parameter int WORD_W = 18,
  parameter int SLOTS  = 32,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [BIT_W-1:0]  bitPos,
  output logic [SLOT_W-1:0] slotPos,
  output logic              wordEnd,
  output logic [SLOT_W-1:0] nextSlot
);

  assign wordEnd  = (bitPos == BIT_W'(WORD_W - 1));
  assign nextSlot = (slotPos == '0) ? SLOT_W'(SLOTS - 1) : slotPos - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos  <= '0;
      slotPos <= SLOT_W'(SLOTS - 1);
    end else if (wordEnd) begin
      bitPos  <= '0;
      slotPos <= nextSlot;
    end else begin
      bitPos  <= bitPos + 1'b1;
    end
  end

  assert_bit_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitPos < BIT_W'(WORD_W));

  assert_slot_descends_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordEnd |=> (slotPos == (($past(slotPos) == '0) ? SLOT_W'(SLOTS - 1)
                                                    : $past(slotPos) - 1'b1)));

  assert_slot_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wordEnd |=> $stable(slotPos));

endmodule

// File: rtl/dlsControl.sv
module dlsControl
  import dlsPkg::*;
#(
  parameter int SLOTS = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqLong,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic              wordEnd,
  input  logic [SLOT_W-1:0] nextSlot,
  output dlsStrobes_t       strb,
  output logic              busy,
  output logic              done
);

  typedef enum logic [1:0] {ST_BOOT, ST_IDLE, ST_WAIT, ST_XFER} ctlState_t;

  ctlState_t         state;
  logic [SLOT_W-1:0] targetSlot;
  logic              writeR;
  logic              highR;
  logic              doneR;
  logic [SLOT_W-1:0] reqStart;
  logic              accept;
  logic              startNow;
  logic              waitHit;
  logic              bootLast;

  // a long pair starts at its odd upper slot
  assign reqStart = reqLong ? {reqSlot[SLOT_W-1:1], 1'b1} : reqSlot;
  assign accept   = (state == ST_IDLE) && reqValid;
  assign startNow = wordEnd && (nextSlot == reqStart);
  assign waitHit  = wordEnd && (nextSlot == targetSlot);
  assign bootLast = wordEnd && (nextSlot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_BOOT;
      targetSlot <= '0;
      writeR     <= 1'b0;
      highR      <= 1'b0;
      doneR      <= 1'b0;
    end else begin
      doneR <= 1'b0;
      unique case (state)
        ST_BOOT: if (bootLast) state <= ST_IDLE;
        ST_IDLE: if (accept) begin
          targetSlot <= reqStart;
          writeR     <= reqWrite;
          highR      <= reqLong;
          state      <= startNow ? ST_XFER : ST_WAIT;
        end
        ST_WAIT: if (waitHit) state <= ST_XFER;
        ST_XFER: if (wordEnd) begin
          if (highR) begin
            highR <= 1'b0;
          end else begin
            state <= ST_IDLE;
            doneR <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture  = accept;
    strb.bootWr   = (state == ST_BOOT);
    strb.xferEn   = (state == ST_XFER);
    strb.isWrite  = accept ? reqWrite : writeR;
    strb.highHalf = highR;
  end

  assign busy = (state != ST_IDLE);
  assign done = doneR;

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_xfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(strb.xferEn));

endmodule

// File: rtl/dlsDatapath.sv
module dlsDatapath
  import dlsPkg::*;
#(
  parameter int WORD_W     = 18,
  parameter int SLOTS      = 32,
  parameter int TANKS      = 32,
  parameter int BOOT_WORDS = 31,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TANK_W = $clog2(TANKS),
  localparam int ADDR_W = TANK_W + SLOT_W,
  localparam int DEPTH  = TANKS * SLOTS,
  localparam int LONG_W = 2 * WORD_W,
  localparam int IDX_W  = $clog2(LONG_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dlsStrobes_t       strb,
  input  logic [TANK_W-1:0] reqTank,
  input  logic [LONG_W-1:0] wrData,
  input  logic [BIT_W-1:0]  bitPos,
  input  logic [SLOT_W-1:0] slotPos,
  output logic [LONG_W-1:0] rdData
);

  logic [WORD_W-1:0] store [DEPTH];
  logic [TANK_W-1:0] tankR;
  logic [LONG_W-1:0] dataReg;
  logic [IDX_W-1:0]  idx;
  logic              gapBit;
  logic [ADDR_W-1:0] headAddr;
  logic              headBit;
  logic [WORD_W-1:0] bootWord;

  assign idx      = strb.highHalf ? IDX_W'(WORD_W) + IDX_W'(bitPos) : IDX_W'(bitPos);
  assign gapBit   = (bitPos == '0) && !strb.highHalf;
  assign headAddr = {tankR, slotPos};
  assign headBit  = store[headAddr][bitPos];
  assign bootWord = (32'(slotPos) < 32'(BOOT_WORDS))
                    ? WORD_W'(bootPattern(32'(slotPos))) : '0;

  always_ff @(posedge clk) begin
    if (strb.bootWr)
      store[{TANK_W'(0), slotPos}][bitPos] <= bootWord[bitPos];
    else if (strb.xferEn && strb.isWrite && !gapBit)
      store[headAddr][bitPos] <= dataReg[idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tankR   <= '0;
      dataReg <= '0;
    end else if (strb.capture) begin
      tankR   <= reqTank;
      dataReg <= strb.isWrite ? wrData : '0;
    end else if (strb.xferEn && !strb.isWrite) begin
      dataReg[idx] <= gapBit ? 1'b0 : headBit;
    end
  end

  assign rdData = dataReg;

  assert_xfer_word_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.xferEn) |-> (bitPos == '0));

  assert_upper_slot_odd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xferEn && strb.highHalf) |-> slotPos[0]);

  assert_boot_not_xfer_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.bootWr |-> !strb.capture);

endmodule

// File: rtl/circDelayStore.sv
module circDelayStore
  import dlsPkg::*;
#(
  parameter int WORD_W     = 18,
  parameter int SLOTS      = 32,
  parameter int TANKS      = 32,
  parameter int BOOT_WORDS = 31,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TANK_W = $clog2(TANKS),
  localparam int ADDR_W = TANK_W + SLOT_W,
  localparam int LONG_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqLong,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LONG_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic [LONG_W-1:0] rdData
);

  dlsStrobes_t       strb;
  logic [BIT_W-1:0]  bitPos;
  logic [SLOT_W-1:0] slotPos;
  logic [SLOT_W-1:0] nextSlot;
  logic              wordEnd;

  dlsTiming #(.WORD_W(WORD_W), .SLOTS(SLOTS)) uTiming (
    .clk(clk), .rstN(rstN), .bitPos(bitPos), .slotPos(slotPos),
    .wordEnd(wordEnd), .nextSlot(nextSlot)
  );

  dlsControl #(.SLOTS(SLOTS)) uControl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLong(reqLong), .reqSlot(reqAddr[SLOT_W-1:0]), .wordEnd(wordEnd),
    .nextSlot(nextSlot), .strb(strb), .busy(busy), .done(done)
  );

  dlsDatapath #(.WORD_W(WORD_W), .SLOTS(SLOTS), .TANKS(TANKS),
                .BOOT_WORDS(BOOT_WORDS)) uDatapath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqTank(reqAddr[ADDR_W-1:SLOT_W]),
    .wrData(wrData), .bitPos(bitPos), .slotPos(slotPos), .rdData(rdData)
  );

endmodule

// File: tb/circDelayStore_test.sv
module circDelayStore_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqLong = 1'b0;
  logic [9:0]  reqAddr = '0;
  logic [35:0] wrData = '0;
  logic        busy;
  logic        done;
  logic [35:0] rdData;

  int errors = 0;
  int checks = 0;
  int cyc;
  logic [17:0] model [1024];

  circDelayStore uut (.*);

  always #2 clk = ~clk;

  always @(posedge clk or negedge rstN)
    if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  // {write, long, addr[9:0], data[35:0]}
  localparam logic [47:0] VEC [15] = '{
    {1'b0, 1'b0, 10'd0,    36'h0},
    {1'b0, 1'b0, 10'd30,   36'h0},
    {1'b0, 1'b0, 10'd31,   36'h0},
    {1'b0, 1'b1, 10'd4,    36'h0},
    {1'b1, 1'b0, 10'd237,  36'h0_0002_A5A7},
    {1'b0, 1'b0, 10'd237,  36'h0},
    {1'b1, 1'b1, 10'd1022, 36'h9_ABCD_1235},
    {1'b0, 1'b1, 10'd1022, 36'h0},
    {1'b0, 1'b1, 10'd1023, 36'h0},
    {1'b1, 1'b0, 10'd31,   36'hF_FFF3_FFFF},
    {1'b0, 1'b0, 10'd31,   36'h0},
    {1'b1, 1'b0, 10'd37,   36'hA_5551_2345},
    {1'b0, 1'b0, 10'd37,   36'h0},
    {1'b0, 1'b0, 10'd1022, 36'h0},
    {1'b0, 1'b0, 10'd1023, 36'h0}
  };

  function automatic logic [17:0] bootVal(int i);
    logic [31:0] v;
    v = 32'(i) * 32'd2749 + 32'd1234;
    return (i < 31) ? (18'(v) & 18'h3FFFE) : 18'h0;
  endfunction

  function automatic int startCycle(int k, int slot);
    for (int m = k + 1; m <= k + 700; m++)
      if ((31 - ((m / 18) % 32)) == slot && (m % 18) == 0) return m;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] expectRead(bit lng, logic [9:0] a);
    logic [9:0] n;
    if (lng) begin
      n = {a[9:1], 1'b0};
      return {model[n + 10'd1], model[n][17:1], 1'b0};
    end
    return {18'h0, model[a][17:1], 1'b0};
  endfunction

  task automatic doOp(input bit wr, input bit lng, input logic [9:0] a,
                      input logic [35:0] d, input string tag);
    int k, expDone, guard;
    logic [9:0] n;
    @(negedge clk);
    guard = 0;
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
    k = cyc;
    reqValid = 1'b1; reqWrite = wr; reqLong = lng; reqAddr = a; wrData = d;
    @(negedge clk);
    reqValid = 1'b0;
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    expDone = startCycle(k, lng ? int'({a[4:1], 1'b1}) : int'(a[4:0])) + (lng ? 36 : 18);
    // R4 / R6: completion cycle follows the circulation phase
    check(cyc == expDone, lng ? "R6 long done cycle" : "R4 short done cycle",
          36'(cyc), 36'(expDone));
    check(!busy, "R4 busy low at done", 36'(busy), 36'h0);
    if (wr) begin
      if (lng) begin
        n = {a[9:1], 1'b0};
        model[n + 10'd1] = d[35:18];
        model[n] = {d[17:1], model[n][0]};
      end else begin
        model[a] = {d[17:1], model[a][0]};
      end
    end else begin
      check(rdData == expectRead(lng, a), tag, rdData, expectRead(lng, a));
    end
    @(negedge clk);
    check(!done, "R9 done single pulse", 36'(done), 36'h0);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = (i < 32) ? bootVal(i) : 18'h0;
    repeat (3) @(negedge clk);
    check(busy == 1'b1 && done == 1'b0, "R2 reset state busy/done",
          {34'h0, busy, done}, 36'h2);
    rstN = 1'b1;

    // R7: request during the loader is ignored (tank 0 slot 3)
    while (cyc < 100) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqLong = 1'b0; reqAddr = 10'd3;
    wrData = '1;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;

    while (cyc < 575) @(negedge clk);
    check(busy == 1'b1, "R2 busy through loader", 36'(busy), 36'h1);
    @(negedge clk);
    check(busy == 1'b0, "R2 busy drops at 576", 36'(busy), 36'h0);

    doOp(1'b0, 1'b0, 10'd3, 36'h0, "R7 loader-time write ignored");

    // R1 R2 R5 R6: table of vectors
    for (int v = 0; v < 15; v++)
      doOp(VEC[v][47], VEC[v][46], VEC[v][45:36], VEC[v][35:0],
           VEC[v][46] ? "R6 long read data" : "R5 R1 short read data");

    // R7: request while a transfer is in progress is ignored
    doOp(1'b1, 1'b0, 10'd291, 36'h0_0001_5555, "R7 setup");
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqLong = 1'b0; reqAddr = 10'd290;
    wrData = 36'h0_0000_0F0F;
    @(negedge clk);
    reqAddr = 10'd291; wrData = 36'h0_0003_FFFF;
    @(negedge clk);
    check(busy == 1'b1, "R7 busy while transfer pending", 36'(busy), 36'h1);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
    doOp(1'b0, 1'b0, 10'd291, 36'h0, "R7 busy-time write ignored");

    // R8: retention over many circulations
    repeat (3000) @(negedge clk);
    doOp(1'b0, 1'b0, 10'd237, 36'h0, "R8 short word retained");
    doOp(1'b0, 1'b1, 10'd1022, 36'h0, "R8 long word retained");
    doOp(1'b0, 1'b0, 10'd17, 36'h0, "R8 R2 boot word retained");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule